// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel Engine

This block is a single DMA channel. Software starts it with a one-cycle pulse. In descriptor mode the channel first reads a 16-byte descriptor through a word-wide memory master port. The four words are the link pointer, the source address, the target address and the command. It then moves the data from source to target in bursts. Each burst reads all of its elements into a local buffer before it writes any of them back. Element width, burst size, address stepping and flow control all come from the command word. When a transfer ends, the channel either follows the link pointer to the next descriptor or stops.

The low bits of the link pointer carry two controls. One is a stop marker. The other is a branch enable, which moves the fetch 32 bytes further on when the compare input is high. A peripheral request input paces flow-controlled transfers. If the request drops after a burst, the channel records an end-of-receive event. It then stops or jumps to the next descriptor, depending on two enable inputs. In direct mode no descriptor is fetched. Source, target and command are taken from configuration ports when the start pulse arrives. Status flags and the live source address, target address and remaining length are plain outputs.

Top module: `dma_chain_engine`

## Requirements
- R1: In descriptor mode a start, a chain step or an end-of-receive jump fetches four words with size code 2. They come from the link pointer with bits 3:0 cleared, at offsets 0, 4, 8 and 12, and hold in turn the link pointer, source address, target address and command.
- R2: When link pointer bit 1 and `cmp_flag_i` are both set at the moment a fetch begins, the fetch base moves up by 32 bytes.
- R3: Command bits 12:0 give the byte length. Bits 15:14 give the element width: 1 is 1 byte, 2 is 2 bytes, 3 is 4 bytes. Bits 17:16 give the burst size as 4 shifted left by the field. Each burst moves min(length, burst size) bytes, and all of its reads (`mem_we_o`=0) finish before its first write (`mem_we_o`=1). Memory accesses use size code 0, 1 or 2 for 1, 2 or 4 bytes, with data in the low bytes.
- R4: Command bit 31 steps the source address and bit 30 steps the target address by the element width after each element. With the bit clear, that address holds.
- R5: Command bit 29 marks the source as flow controlled and bit 28 marks the target. In either case the low two bits of the marked address are cleared at fetch. A burst starts only while `req_i` is high, and no data access is issued while the channel waits for it.
- R6: After each burst, the remaining length (`rem_len_o`) drops by that burst's byte count. It does not change while a burst is in progress.
- R7: If `req_i` is low after a burst of a flow-controlled transfer, `eor_flag_o` is set. The channel then stops if `eor_stop_en_i` is set. Otherwise it fetches the next descriptor if `eor_jump_en_i` is set and descriptor mode is active.
- R8: When the remaining length reaches zero, `end_flag_o` is set if command bit 21 is set. The channel stops (`run_o`=0, `stopped_o`=1) in direct mode, when link pointer bit 0 is set, or when `eor_stop_en_i` is set. Otherwise it fetches the descriptor the link pointer names.
- R9: A descriptor fetch whose command has bit 22 set sets `start_flag_o`.
- R10: A width field of 0 stops the channel before any data access, leaving the length unchanged.
- R11: The memory port has one access outstanding at most. `mem_req_o` and the address hold until `mem_gnt_i`, and no new request is made until `mem_rvalid_i` has returned.
- R12: After reset, `run_o`=0, `stopped_o`=1, all event flags are 0 and `mem_req_o`=0. A start clears the event flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken while idle |
| desc_mode_i | input | 1 | 1: fetch descriptors, 0: direct mode |
| desc_ptr_i | input | 32 | First link pointer (descriptor mode) |
| cfg_src_i | input | 32 | Source address (direct mode) |
| cfg_tgt_i | input | 32 | Target address (direct mode) |
| cfg_cmd_i | input | 32 | Command word (direct mode) |
| cmp_flag_i | input | 1 | Compare status for branching |
| eor_stop_en_i | input | 1 | Stop on end-of-receive or completion |
| eor_jump_en_i | input | 1 | Jump to next descriptor on end-of-receive |
| req_i | input | 1 | Peripheral request |
| mem_req_o | output | 1 | Memory access valid |
| mem_gnt_i | input | 1 | Memory access accepted |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_size_o | output | 2 | log2 of access bytes |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data, low-justified |
| mem_rvalid_i | input | 1 | Response for the outstanding access |
| mem_rdata_i | input | 32 | Read data, low-justified |
| run_o | output | 1 | Channel running |
| stopped_o | output | 1 | Channel stopped |
| start_flag_o | output | 1 | Start event |
| end_flag_o | output | 1 | End event |
| eor_flag_o | output | 1 | End-of-receive event |
| rem_len_o | output | 13 | Remaining byte length |
| src_addr_o | output | 32 | Current source address |
| tgt_addr_o | output | 32 | Current target address |

## Verification
Every memory access takes at least four cycles from the engine's decision to its completion, and the grant is withheld one cycle in four. Final results are therefore only due once `run_o` has fallen. The bench polls `run_o` on falling edges and samples flags, addresses, remaining length and memory contents at the first falling edge where it reads low. The flow-control wait is checked 30 cycles after the start pulse, by which point the four descriptor reads are long complete and no data access may have appeared. The end-of-receive case drops `req_i` on the falling edge right after the burst's write is accepted. That is two cycles before the engine decides what follows the burst. Read and write ordering within bursts is checked from a log of accepted accesses.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LEN_W  = 13;

  localparam int unsigned B_INC_SRC   = 31;
  localparam int unsigned B_INC_TGT   = 30;
  localparam int unsigned B_FLOW_SRC  = 29;
  localparam int unsigned B_FLOW_TGT  = 28;
  localparam int unsigned B_START_IRQ = 22;
  localparam int unsigned B_END_IRQ   = 21;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_RD, ST_WR, ST_POST
  } eng_state_e;

  typedef enum logic [1:0] {MI_IDLE, MI_REQ, MI_WAIT} mi_state_e;

  function automatic logic [ADDR_W-1:0] desc_base(input logic [ADDR_W-1:0] p,
                                                  input logic cmp);
    desc_base = {p[ADDR_W-1:4], 4'h0} + ((p[1] && cmp) ? 32'd32 : 32'd0);
  endfunction
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode import dma_chain_pkg::*; #(
  parameter int unsigned MAX_BURST_BYTES = 32,
  localparam int unsigned IDX_W = $clog2(MAX_BURST_BYTES + 1)
) (
  input  logic [DATA_W-1:0] cmd_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              width_ok_o,
  output logic [1:0]        wsh_o,
  output logic [2:0]        width_b_o,
  output logic [IDX_W-1:0]  burst_bytes_o,
  output logic [IDX_W-1:0]  burst_elems_o
);
  logic [IDX_W-1:0] size_b;

  always_comb begin
    len_o         = cmd_i[LEN_W-1:0];
    width_ok_o    = cmd_i[15:14] != 2'd0;
    wsh_o         = cmd_i[15:14] - 2'd1;
    width_b_o     = 3'd1 << wsh_o;
    size_b        = IDX_W'(4) << cmd_i[17:16];
    burst_bytes_o = (len_o < LEN_W'(size_b)) ? IDX_W'(len_o) : size_b;
    burst_elems_o = burst_bytes_o >> wsh_o;
  end
endmodule

// File: rtl/dma_burst_buf.sv
module dma_burst_buf #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned IDX_W = 6,
  localparam int unsigned SEL_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o
);
  logic [DW-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_idx_i == IDX_W'(g))) ent_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = ent_q[rd_idx_i[SEL_W-1:0]];
endmodule

// File: rtl/dma_mem_if.sv
module dma_mem_if import dma_chain_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic              mem_we_o,
  output logic [1:0]        mem_size_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  mi_state_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= MI_IDLE;
      mem_we_o    <= 1'b0;
      mem_size_o  <= 2'd0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      case (st_q)
        MI_IDLE: if (go_i) begin
          st_q        <= MI_REQ;
          mem_we_o    <= we_i;
          mem_size_o  <= size_i;
          mem_addr_o  <= addr_i;
          mem_wdata_o <= wdata_i;
        end
        MI_REQ:  if (mem_gnt_i) st_q <= MI_WAIT;
        MI_WAIT: if (mem_rvalid_i) st_q <= MI_IDLE;
        default: st_q <= MI_IDLE;
      endcase
    end
  end

  assign mem_req_o = st_q == MI_REQ;
  assign done_o    = (st_q == MI_WAIT) && mem_rvalid_i;
  assign rdata_o   = mem_rdata_i;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i |=> !mem_req_o); // R11
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine import dma_chain_pkg::*; #(
  parameter int unsigned MAX_BURST_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              desc_mode_i,
  input  logic [31:0]       desc_ptr_i,
  input  logic [31:0]       cfg_src_i,
  input  logic [31:0]       cfg_tgt_i,
  input  logic [31:0]       cfg_cmd_i,
  input  logic              cmp_flag_i,
  input  logic              eor_stop_en_i,
  input  logic              eor_jump_en_i,
  input  logic              req_i,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic              mem_we_o,
  output logic [1:0]        mem_size_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              run_o,
  output logic              stopped_o,
  output logic              start_flag_o,
  output logic              end_flag_o,
  output logic              eor_flag_o,
  output logic [12:0]       rem_len_o,
  output logic [31:0]       src_addr_o,
  output logic [31:0]       tgt_addr_o
);
  localparam int unsigned IDX_W = $clog2(MAX_BURST_BYTES + 1);

  eng_state_e         st_q;
  logic [ADDR_W-1:0]  ptr_q, src_q, tgt_q, fbase_q;
  logic [DATA_W-1:0]  cmd_q;
  logic [1:0]         word_q;
  logic [IDX_W-1:0]   idx_q, elems_q, bbytes_q;
  logic               acc_pend_q, desc_mode_q;

  logic [LEN_W-1:0]   len;
  logic               width_ok;
  logic [1:0]         wsh;
  logic [2:0]         width_b;
  logic [IDX_W-1:0]   d_bytes, d_elems;

  logic               need_acc, acc_go, acc_we, acc_done;
  logic [1:0]         acc_size;
  logic [ADDR_W-1:0]  acc_addr, step;
  logic [DATA_W-1:0]  acc_rdata, buf_rdata;
  logic               flow, waiting_req, cmpl_stop;
  logic               do_cmpl, do_stop, do_fetch, do_eor;

  dma_cmd_decode #(.MAX_BURST_BYTES(MAX_BURST_BYTES)) i_dec (
    .cmd_i(cmd_q), .len_o(len), .width_ok_o(width_ok), .wsh_o(wsh),
    .width_b_o(width_b), .burst_bytes_o(d_bytes), .burst_elems_o(d_elems)
  );

  dma_burst_buf #(.DEPTH(MAX_BURST_BYTES), .DW(DATA_W), .IDX_W(IDX_W)) i_buf (
    .clk_i(clk_i), .wr_en_i((st_q == ST_RD) && acc_done), .wr_idx_i(idx_q),
    .wr_data_i(acc_rdata), .rd_idx_i(idx_q), .rd_data_o(buf_rdata)
  );

  dma_mem_if i_mif (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(acc_go), .we_i(acc_we),
    .size_i(acc_size), .addr_i(acc_addr), .wdata_i(buf_rdata),
    .done_o(acc_done), .rdata_o(acc_rdata),
    .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i), .mem_we_o(mem_we_o),
    .mem_size_o(mem_size_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i)
  );

  assign flow        = cmd_q[B_FLOW_SRC] | cmd_q[B_FLOW_TGT];
  assign waiting_req = flow && !req_i;
  assign cmpl_stop   = !desc_mode_q || ptr_q[0] || eor_stop_en_i;
  assign step        = {29'd0, width_b};

  always_comb begin
    need_acc = 1'b0;
    acc_we   = 1'b0;
    acc_size = 2'd2;
    acc_addr = fbase_q + {28'd0, word_q, 2'b00};
    case (st_q)
      ST_FETCH: need_acc = 1'b1;
      ST_RD: begin
        need_acc = idx_q != elems_q;
        acc_size = wsh;
        acc_addr = src_q;
      end
      ST_WR: begin
        need_acc = idx_q != elems_q;
        acc_we   = 1'b1;
        acc_size = wsh;
        acc_addr = tgt_q;
      end
      default: ;
    endcase
  end
  assign acc_go = need_acc && !acc_pend_q;

  // what follows a length check or a finished burst
  always_comb begin
    do_cmpl = 1'b0;
    do_stop = 1'b0;
    do_fetch = 1'b0;
    do_eor = 1'b0;
    if (st_q == ST_CHECK) begin
      if (!width_ok) do_stop = 1'b1;
      else if (len == '0) do_cmpl = 1'b1;
    end else if (st_q == ST_POST) begin
      if (waiting_req) begin
        do_eor = 1'b1;
        if (eor_stop_en_i) do_stop = 1'b1;
        else if (eor_jump_en_i && desc_mode_q) do_fetch = 1'b1;
        else if (len == '0) do_cmpl = 1'b1;
      end else if (len == '0) begin
        do_cmpl = 1'b1;
      end
    end
    if (do_cmpl) begin
      if (cmpl_stop) do_stop = 1'b1;
      else do_fetch = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      ptr_q        <= '0;
      src_q        <= '0;
      tgt_q        <= '0;
      cmd_q        <= '0;
      fbase_q      <= '0;
      word_q       <= 2'd0;
      idx_q        <= '0;
      elems_q      <= '0;
      bbytes_q     <= '0;
      acc_pend_q   <= 1'b0;
      desc_mode_q  <= 1'b0;
      run_o        <= 1'b0;
      stopped_o    <= 1'b1;
      start_flag_o <= 1'b0;
      end_flag_o   <= 1'b0;
      eor_flag_o   <= 1'b0;
    end else begin
      if (acc_go) acc_pend_q <= 1'b1;
      else if (acc_done) acc_pend_q <= 1'b0;

      case (st_q)
        ST_IDLE: if (start_i) begin
          run_o        <= 1'b1;
          stopped_o    <= 1'b0;
          start_flag_o <= 1'b0;
          end_flag_o   <= 1'b0;
          eor_flag_o   <= 1'b0;
          desc_mode_q  <= desc_mode_i;
          if (desc_mode_i) begin
            fbase_q <= desc_base(desc_ptr_i, cmp_flag_i);
            word_q  <= 2'd0;
            st_q    <= ST_FETCH;
          end else begin
            src_q <= cfg_src_i;
            tgt_q <= cfg_tgt_i;
            cmd_q <= cfg_cmd_i;
            st_q  <= ST_CHECK;
          end
        end
        ST_FETCH: if (acc_done) begin
          word_q <= word_q + 2'd1;
          case (word_q)
            2'd0: ptr_q <= acc_rdata;
            2'd1: src_q <= acc_rdata;
            2'd2: tgt_q <= acc_rdata;
            default: begin
              cmd_q <= acc_rdata;
              if (acc_rdata[B_FLOW_SRC]) src_q[1:0] <= 2'b00;
              if (acc_rdata[B_FLOW_TGT]) tgt_q[1:0] <= 2'b00;
              if (acc_rdata[B_START_IRQ]) start_flag_o <= 1'b1;
              st_q <= ST_CHECK;
            end
          endcase
        end
        ST_CHECK: if (width_ok && (len != '0) && !waiting_req) begin
          elems_q  <= d_elems;
          bbytes_q <= d_bytes;
          idx_q    <= '0;
          st_q     <= ST_RD;
        end
        ST_RD: begin
          if (acc_done) begin
            idx_q <= idx_q + IDX_W'(1);
            if (cmd_q[B_INC_SRC]) src_q <= src_q + step;
          end else if (!acc_pend_q && (idx_q == elems_q)) begin
            idx_q <= '0;
            st_q  <= ST_WR;
          end
        end
        ST_WR: begin
          if (acc_done) begin
            idx_q <= idx_q + IDX_W'(1);
            if (cmd_q[B_INC_TGT]) tgt_q <= tgt_q + step;
          end else if (!acc_pend_q && (idx_q == elems_q)) begin
            cmd_q[LEN_W-1:0] <= len - LEN_W'(bbytes_q);
            st_q <= ST_POST;
          end
        end
        ST_POST: st_q <= ST_CHECK;
        default: st_q <= ST_IDLE;
      endcase

      if (do_eor) eor_flag_o <= 1'b1;
      if (do_cmpl && cmd_q[B_END_IRQ]) end_flag_o <= 1'b1;
      if (do_stop) begin
        run_o     <= 1'b0;
        stopped_o <= 1'b1;
        st_q      <= ST_IDLE;
      end else if (do_fetch) begin
        fbase_q <= desc_base(ptr_q, cmp_flag_i);
        word_q  <= 2'd0;
        st_q    <= ST_FETCH;
      end
    end
  end

  assign rem_len_o  = cmd_q[LEN_W-1:0];
  assign src_addr_o = src_q;
  assign tgt_addr_o = tgt_q;

  AST_FETCH_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FETCH) && mem_req_o |-> !mem_we_o && (mem_addr_o[1:0] == 2'b00) && (mem_size_o == 2'd2)); // R1
  AST_RD_PHASE_READS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD) && mem_req_o |-> !mem_we_o); // R3
  AST_WR_PHASE_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR) && mem_req_o |-> mem_we_o); // R3
  AST_FLOW_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHECK) && width_ok && (len != '0) && waiting_req |=> (st_q == ST_CHECK) && !mem_req_o); // R5
  AST_LEN_STABLE_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD) |=> $stable(rem_len_o)); // R6
  AST_STOP_DROPS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stopped_o) |-> !run_o); // R8
  AST_WIDTH0_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_CHECK) && !width_ok |=> !run_o && stopped_o && $stable(rem_len_o)); // R10
endmodule

// File: tb/test_dma_chain_engine.sv
module test_dma_chain_engine;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, desc_mode_i = 1'b1, cmp_flag_i = 1'b0;
  logic eor_stop_en_i = 1'b0, eor_jump_en_i = 1'b0, req_i = 1'b0;
  logic [31:0] desc_ptr_i = '0, cfg_src_i = '0, cfg_tgt_i = '0, cfg_cmd_i = '0;
  logic mem_req_o, mem_we_o, mem_gnt_i, mem_rvalid_i = 1'b0;
  logic [1:0] mem_size_o;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;
  logic run_o, stopped_o, start_flag_o, end_flag_o, eor_flag_o;
  logic [12:0] rem_len_o;
  logic [31:0] src_addr_o, tgt_addr_o;

  int n_chk = 0, n_fail = 0;
  int n_acc = 0, n_wr = 0, log_n = 0, proto_err = 0;
  logic log_we [0:255];
  logic [7:0] mem [0:1023];
  logic out_q = 1'b0;
  logic [1:0] gcnt = 2'd0;

  always #4 clk_i = ~clk_i;

  dma_chain_engine i_dma_chain_engine (.*);

  assign mem_gnt_i = gcnt != 2'd2;

  always @(posedge clk_i) begin : mem_model
    logic [9:0] a;
    logic [31:0] tmp;
    gcnt <= gcnt + 2'd1;
    mem_rvalid_i <= 1'b0;
    if (mem_rvalid_i) out_q <= 1'b0;
    if (mem_req_o && out_q) proto_err <= proto_err + 1;
    if (mem_req_o && mem_gnt_i) begin
      out_q <= 1'b1;
      mem_rvalid_i <= 1'b1;
      n_acc <= n_acc + 1;
      if (mem_we_o) n_wr <= n_wr + 1;
      if (log_n < 256) log_we[log_n] <= mem_we_o;
      log_n <= log_n + 1;
      tmp = '0;
      for (int b = 0; b < 4; b++) begin
        a = mem_addr_o[9:0] + 10'(b);
        if (b < (1 << mem_size_o)) begin
          if (mem_we_o) mem[a] <= mem_wdata_o[8*b +: 8];
          else tmp[8*b +: 8] = mem[a];
        end
      end
      if (!mem_we_o) mem_rdata_i <= tmp;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put32(input int addr, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[(addr + b) & 1023] = v[8*b +: 8];
  endtask

  task automatic put_desc(input int addr, input logic [31:0] nx, input logic [31:0] s,
                          input logic [31:0] t, input logic [31:0] c);
    put32(addr, nx); put32(addr + 4, s); put32(addr + 8, t); put32(addr + 12, c);
  endtask

  task automatic clear(input int addr, input int n);
    for (int i = 0; i < n; i++) mem[(addr + i) & 1023] = 8'h00;
  endtask

  task automatic chk_copy(input string req, input int s, input int d, input int n);
    for (int i = 0; i < n; i++) chk(req, "copied byte", {24'd0, mem[d + i]}, {24'd0, mem[s + i]});
  endtask

  task automatic kick(input logic dm, input logic [31:0] ptr);
    @(negedge clk_i);
    desc_mode_i = dm;
    desc_ptr_i = ptr;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (run_o && k < 3000) begin
      @(negedge clk_i);
      k++;
    end
    chk(req, "channel went idle", {31'd0, run_o}, 32'd0);
  endtask

  localparam logic [31:0] INC2 = 32'hC000_0000;
  localparam logic [31:0] W4 = 32'h0000_C000;
  localparam logic [31:0] B8 = 32'h0001_0000;
  localparam logic [31:0] ENDI = 32'h0020_0000;
  localparam logic [31:0] STI = 32'h0040_0000;

  task automatic t_reset;
    chk("R12", "run", {31'd0, run_o}, 0);
    chk("R12", "stopped", {31'd0, stopped_o}, 1);
    chk("R12", "flags", {29'd0, start_flag_o, end_flag_o, eor_flag_o}, 0);
    chk("R12", "mem_req", {31'd0, mem_req_o}, 0);
  endtask

  // R1 R3 R4 R6 R8 R9: 16 bytes, 4-byte elements, 8-byte bursts
  task automatic t_basic;
    int lb;
    clear(32'h300, 16);
    put_desc(32'h100, 32'h1, 32'h200, 32'h300, INC2 | STI | ENDI | B8 | W4 | 16);
    lb = log_n;
    kick(1'b1, 32'h100);
    wait_idle("R8");
    chk_copy("R1", 32'h200, 32'h300, 16);
    chk("R3", "access count", n_acc - (lb == 0 ? 0 : 0), 32'(lb + 12));
    for (int i = 0; i < 12; i++)
      chk("R3", "access order", {31'd0, log_we[lb + i]}, (i >= 4 && ((i - 4) % 4) >= 2) ? 1 : 0);
    chk("R4", "src end", src_addr_o, 32'h210);
    chk("R4", "tgt end", tgt_addr_o, 32'h310);
    chk("R6", "rem len", {19'd0, rem_len_o}, 0);
    chk("R8", "end flag", {31'd0, end_flag_o}, 1);
    chk("R8", "stopped", {31'd0, stopped_o}, 1);
    chk("R9", "start flag", {31'd0, start_flag_o}, 1);
  endtask

  // R4 R3: byte width, 4-byte bursts, target address held
  task automatic t_width1;
    clear(32'h380, 8);
    put_desc(32'h180, 32'h1, 32'h240, 32'h380, 32'h8000_0000 | 32'h4000 | 6);
    kick(1'b1, 32'h180);
    wait_idle("R4");
    chk("R4", "held target byte", {24'd0, mem[32'h380]}, {24'd0, mem[32'h245]});
    chk("R4", "neighbour untouched", {24'd0, mem[32'h381]}, 0);
    chk("R4", "src end", src_addr_o, 32'h246);
    chk("R4", "tgt held", tgt_addr_o, 32'h380);
    chk("R8", "no end flag", {31'd0, end_flag_o}, 0);
    chk("R9", "no start flag", {31'd0, start_flag_o}, 0);
  endtask

  // R2: branch bit with compare set fetches 32 bytes on
  task automatic t_branch;
    clear(32'h300, 16);
    clear(32'h340, 8);
    put_desc(32'h120, 32'h1, 32'h260, 32'h340, INC2 | B8 | W4 | 8);
    cmp_flag_i = 1'b1;
    kick(1'b1, 32'h10E);
    cmp_flag_i = 1'b0;
    wait_idle("R2");
    chk_copy("R2", 32'h260, 32'h340, 8);
    chk("R2", "unbranched target untouched", {24'd0, mem[32'h300]}, 0);
  endtask

  // R8: two linked descriptors
  task automatic t_chain;
    int ab;
    clear(32'h3a0, 8);
    clear(32'h3c0, 8);
    put_desc(32'h140, 32'h160, 32'h200, 32'h3a0, INC2 | B8 | W4 | 8);
    put_desc(32'h160, 32'h1, 32'h208, 32'h3c0, INC2 | ENDI | B8 | W4 | 8);
    ab = n_acc;
    kick(1'b1, 32'h140);
    wait_idle("R8");
    chk_copy("R8", 32'h200, 32'h3a0, 8);
    chk_copy("R8", 32'h208, 32'h3c0, 8);
    chk("R8", "chain accesses", 32'(n_acc - ab), 16);
    chk("R8", "end flag", {31'd0, end_flag_o}, 1);
  endtask

  // R5 R7: flow-controlled source, request dropped after the first burst
  task automatic t_flow(input logic jump);
    int ab, wb, k;
    clear(32'h3d0, 16);
    clear(32'h3e0, 8);
    put_desc(32'h1a0, 32'h1c0, 32'h283, 32'h3d0, 32'h6000_0000 | W4 | 12);
    put_desc(32'h1c0, 32'h1, 32'h200, 32'h3e0, INC2 | ENDI | B8 | W4 | 4);
    eor_stop_en_i = !jump;
    eor_jump_en_i = jump;
    req_i = 1'b0;
    ab = n_acc;
    kick(1'b1, 32'h1a0);
    repeat (30) @(negedge clk_i);
    chk("R5", "waits for request", {31'd0, run_o}, 1);
    chk("R5", "no data access", 32'(n_acc - ab), 4);
    chk("R5", "src low bits cleared", src_addr_o, 32'h280);
    chk("R5", "len untouched", {19'd0, rem_len_o}, 12);
    wb = n_wr;
    req_i = 1'b1;
    k = 0;
    while (n_wr == wb && k < 500) begin
      @(negedge clk_i);
      k++;
    end
    req_i = 1'b0;
    wait_idle("R7");
    chk("R7", "eor flag", {31'd0, eor_flag_o}, 1);
    chk("R7", "stopped", {31'd0, stopped_o}, 1);
    chk_copy("R7", 32'h280, 32'h3d0, 4);
    chk("R7", "second word not moved", {24'd0, mem[32'h3d4]}, 0);
    if (!jump) begin
      chk("R7", "rem len after stop", {19'd0, rem_len_o}, 8);
      chk("R7", "tgt after stop", tgt_addr_o, 32'h3d4);
    end else begin
      chk_copy("R7", 32'h200, 32'h3e0, 4);
      chk("R7", "end flag after jump", {31'd0, end_flag_o}, 1);
      chk("R7", "rem len after jump", {19'd0, rem_len_o}, 0);
    end
    eor_stop_en_i = 1'b0;
    eor_jump_en_i = 1'b0;
  endtask

  // R10: width field 0
  task automatic t_width0;
    int ab;
    put_desc(32'h1e0, 32'h0, 32'h200, 32'h3f0, INC2 | B8 | 8);
    ab = n_acc;
    kick(1'b1, 32'h1e0);
    wait_idle("R10");
    chk("R10", "fetch only", 32'(n_acc - ab), 4);
    chk("R10", "len kept", {19'd0, rem_len_o}, 8);
    chk("R10", "stopped", {31'd0, stopped_o}, 1);
    chk("R10", "src kept", src_addr_o, 32'h200);
  endtask

  // R8: direct mode, no fetch, stops at completion
  task automatic t_direct;
    int lb;
    clear(32'h3f8, 8);
    cfg_src_i = 32'h2c0;
    cfg_tgt_i = 32'h3f8;
    cfg_cmd_i = INC2 | ENDI | B8 | W4 | 8;
    lb = log_n;
    kick(1'b0, 32'h0);
    wait_idle("R8");
    chk_copy("R8", 32'h2c0, 32'h3f8, 8);
    chk("R8", "direct accesses", 32'(log_n - lb), 4);
    chk("R3", "direct order", {28'd0, log_we[lb], log_we[lb+1], log_we[lb+2], log_we[lb+3]}, 32'h3);
    chk("R8", "end flag", {31'd0, end_flag_o}, 1);
    chk("R12", "start clears start flag", {31'd0, start_flag_o}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) mem[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_width1();
    t_branch();
    t_chain();
    t_flow(1'b0);
    t_flow(1'b1);
    t_width0();
    t_direct();
    chk("R11", "protocol violations", 32'(proto_err), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule